// File: doc/BRIEF.md
# I2C Master Bit Timing Generator

This block turns single-bit bus commands from a byte-level controller into I2C master waveforms. Every command (idle, start, stop, write a bit, read a bit) is spread over five equal phases. Each phase lasts divider + 1 clock cycles, so one bit on the bus takes 5 × (divider + 1) cycles. The block drives open-drain enables for SCL and SDA: an enable of 1 pulls the line low, and an enable of 0 releases it.

The block passes both bus lines through a synchronizer. It returns the sampled read bit, a one-cycle completion pulse and an arbitration-lost pulse. It also keeps a bus-busy flag that follows START and STOP conditions seen on the bus. If a slave holds SCL low after the block releases it, the block stalls at the end of the phase.

The 16-bit divider can be loaded only while the core is disabled. With a 50 MHz clock, the reset value of 302 gives a bus rate of about 33 kHz. A divider of 24 gives 400 kHz.

Top module: `i2c_bit_engine`

## Requirements
- R1: After reset both line enables are 0, cmd_done, arb_lost, bus_busy and rx_bit are 0, and the divider holds 302.
- R2: A divider write (div_wr) takes effect only in a cycle where enable is 0. Writes while enable is 1 leave the bit timing unchanged.
- R3: Command codes on cmd are 0 idle, 1 start, 2 stop, 3 write, 4 read, and 5 to 7 act as idle. A command is accepted when cmd_valid is high, enable is 1 and no command is running. With a divider of at least 2 and no clock stretching, cmd_done pulses for one cycle exactly 5 × (divider + 1) cycles after the accepting edge.
- R4: A start command ends with both enables at 1 and bus_busy set.
- R5: A stop command ends with both enables at 0 and bus_busy cleared.
- R6: During a write, sda_oe equals the inverse of cmd_wbit for the whole command. scl_oe is 1 for exactly 2 × (divider + 1) cycles, in the first and last phases.
- R7: A read leaves SDA released. rx_bit takes the synchronized SDA level at the end of the third phase and holds it until the next read.
- R8: During a write or a read, sda_oe changes only while scl_oe is 1.
- R9: If a write of 1 samples SDA low at the end of the third phase while SCL is high, the block releases both lines and aborts the command. cmd_done and arb_lost then pulse together 3 × (divider + 1) cycles after acceptance. A write of 0 never sets arb_lost.
- R10: If a phase with SCL released is due to end while the synchronized SCL is low, the phase is extended until SCL reads high. With two synchronizer stages and a stretch released T cycles after acceptance (T > 2 × (divider + 1)), a write completes after 3 × (divider + 1) + T + 3 cycles.
- R11: While enable is 0 both lines are released and any running command is dropped without a cmd_done pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enable | input | 1 | Core enable; 0 selects divider-setting mode |
| div_wr | input | 1 | Divider write strobe |
| div_wdata | input | 16 | Divider value to write |
| cmd_valid | input | 1 | Command request |
| cmd | input | 3 | Command code |
| cmd_wbit | input | 1 | Bit to send with a write command |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| cmd_done | output | 1 | One-cycle command completion pulse |
| rx_bit | output | 1 | Last bit sampled by a read |
| bus_busy | output | 1 | Bus held between START and STOP |
| arb_lost | output | 1 | One-cycle arbitration-lost pulse |

## Verification
The bench uses a fixed random seed to pick several dividers and runs start, write, read and stop sequences at each one. Because completion time and SCL low time scale with the divider, these runs separate a correct five-phase count from an off-by-one in phase length. Random write bits and random slave-driven read levels tell an inverted or stuck data path apart from a correct one.

Directed cases cover the remaining behaviour:
- a rival pulling SDA low during a write of 1 and during a write of 0, which separates true arbitration loss from a false alarm;
- a stretched clock with a known release time, which pins the stall to the phase boundary;
- divider writes made while enabled;
- disabling the core in the middle of a command.

// File: rtl/i2cb_pkg.sv
package i2cb_pkg;

  typedef enum logic [2:0] {
    BC_IDLE  = 3'd0,
    BC_START = 3'd1,
    BC_STOP  = 3'd2,
    BC_WRITE = 3'd3,
    BC_READ  = 3'd4
  } bit_cmd_e;

  localparam int unsigned PHASES    = 5;
  localparam int unsigned PH_W      = $clog2(PHASES + 1);
  localparam logic [PH_W-1:0] PH_SAMPLE = PH_W'(2);
  localparam logic [PH_W-1:0] PH_LAST   = PH_W'(PHASES - 1);

  // Line enables {scl_oe, sda_oe} for a command in a given phase.
  function automatic logic [1:0] phase_drive(bit_cmd_e c, logic [PH_W-1:0] ph,
                                             logic wbit, logic [1:0] cur);
    logic [1:0] r;
    r = cur;
    case (c)
      BC_START: begin
        if (ph == 0)      r = {cur[1], 1'b0};
        else if (ph < 3)  r = 2'b00;
        else if (ph == 3) r = 2'b01;
        else              r = 2'b11;
      end
      BC_STOP: begin
        if (ph == 0)      r = 2'b11;
        else if (ph < 3)  r = 2'b01;
        else              r = 2'b00;
      end
      BC_WRITE: r = {(ph == 0) || (ph == PH_LAST), ~wbit};
      BC_READ:  r = {(ph == 0) || (ph == PH_LAST), 1'b0};
      default:  r = cur;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/i2cb_sync.sv
module i2cb_sync #(
  parameter int unsigned WIDTH     = 2,
  parameter int unsigned STAGES    = 2,
  parameter logic [WIDTH-1:0] INIT = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst)         stg[i] <= INIT;
      else if (i == 0) stg[i] <= d;
      else             stg[i] <= stg[(i == 0) ? 0 : i - 1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2cb_divreg.sv
module i2cb_divreg #(
  parameter int unsigned DIV_W         = 16,
  parameter logic [DIV_W-1:0] DIV_INIT = DIV_W'(302)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             wr,
  input  logic [DIV_W-1:0] wdata,
  output logic [DIV_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)               q <= DIV_INIT;
    else if (wr && !enable) q <= wdata;
  end
endmodule

// File: rtl/i2cb_phase_timer.sv
module i2cb_phase_timer
  import i2cb_pkg::*;
#(
  parameter int unsigned DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear,
  input  logic             start,
  input  logic             run,
  input  logic             hold,
  input  logic [DIV_W-1:0] div,
  output logic [PH_W-1:0]  phase,
  output logic             ph_end
);
  logic [DIV_W-1:0] cnt;
  logic             at_limit;

  assign at_limit = (cnt == div);
  assign ph_end   = run && at_limit && !hold;

  always_ff @(posedge clk) begin
    if (rst || clear || start) begin
      cnt   <= '0;
      phase <= '0;
    end else if (run) begin
      if (!at_limit) begin
        cnt <= cnt + 1'b1;
      end else if (!hold) begin
        cnt   <= '0;
        phase <= phase + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cb_busmon.sv
module i2cb_busmon (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic busy
);
  logic scl_d, sda_d;
  logic saw_start, saw_stop;

  assign saw_start = scl_d && scl_s && sda_d && !sda_s;
  assign saw_stop  = scl_d && scl_s && !sda_d && sda_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
      busy  <= 1'b0;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
      if (saw_start)     busy <= 1'b1;
      else if (saw_stop) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/i2c_bit_engine.sv
module i2c_bit_engine
  import i2cb_pkg::*;
#(
  parameter int unsigned DIV_W       = 16,
  parameter int unsigned DIV_INIT    = 302,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enable,
  input  logic             div_wr,
  input  logic [DIV_W-1:0] div_wdata,
  input  logic             cmd_valid,
  input  logic [2:0]       cmd,
  input  logic             cmd_wbit,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             scl_oe,
  output logic             sda_oe,
  output logic             cmd_done,
  output logic             rx_bit,
  output logic             bus_busy,
  output logic             arb_lost
);
  logic [DIV_W-1:0] div_q;
  logic [1:0]       line_s;
  logic             scl_s, sda_s;
  logic [PH_W-1:0]  phase;
  logic             ph_end;
  logic             active_q;
  bit_cmd_e         cmd_q;
  logic             wbit_q;
  logic             accept, hold, sample_pt, arb_hit, clear;

  i2cb_divreg #(.DIV_W(DIV_W), .DIV_INIT(DIV_W'(DIV_INIT))) u_div (
    .clk(clk), .rst(rst), .enable(enable), .wr(div_wr),
    .wdata(div_wdata), .q(div_q)
  );

  i2cb_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(2'b11)) u_sync (
    .clk(clk), .rst(rst), .d({scl_i, sda_i}), .q(line_s)
  );
  assign scl_s = line_s[1];
  assign sda_s = line_s[0];

  i2cb_busmon u_mon (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s), .busy(bus_busy)
  );

  assign accept    = enable && cmd_valid && !active_q;
  assign hold      = !scl_oe && !scl_s;
  assign sample_pt = active_q && ph_end && (phase == PH_SAMPLE);
  assign arb_hit   = sample_pt && (cmd_q == BC_WRITE) && wbit_q && !sda_s && scl_s;
  assign clear     = !enable || arb_hit;

  i2cb_phase_timer #(.DIV_W(DIV_W)) u_tmr (
    .clk(clk), .rst(rst), .clear(clear), .start(accept), .run(active_q),
    .hold(hold), .div(div_q), .phase(phase), .ph_end(ph_end)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      cmd_q    <= BC_IDLE;
      wbit_q   <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      cmd_done <= 1'b0;
      arb_lost <= 1'b0;
      rx_bit   <= 1'b0;
    end else if (!enable) begin
      active_q <= 1'b0;
      scl_oe   <= 1'b0;
      sda_oe   <= 1'b0;
      cmd_done <= 1'b0;
      arb_lost <= 1'b0;
    end else begin
      cmd_done <= 1'b0;
      arb_lost <= 1'b0;
      if (accept) begin
        active_q <= 1'b1;
        cmd_q    <= bit_cmd_e'(cmd);
        wbit_q   <= cmd_wbit;
        {scl_oe, sda_oe} <= phase_drive(bit_cmd_e'(cmd), '0, cmd_wbit, {scl_oe, sda_oe});
      end else if (arb_hit) begin
        active_q <= 1'b0;
        scl_oe   <= 1'b0;
        sda_oe   <= 1'b0;
        cmd_done <= 1'b1;
        arb_lost <= 1'b1;
      end else if (active_q && ph_end) begin
        if (phase == PH_LAST) begin
          active_q <= 1'b0;
          cmd_done <= 1'b1;
        end else begin
          {scl_oe, sda_oe} <= phase_drive(cmd_q, phase + 1'b1, wbit_q, {scl_oe, sda_oe});
        end
      end
      if (sample_pt && cmd_q == BC_READ) rx_bit <= sda_s;
    end
  end
endmodule

// File: rtl/i2cb_checker.sv
module i2cb_checker #(
  parameter int unsigned DIV_W = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             enable,
  input logic [DIV_W-1:0] div_q,
  input logic             scl_oe,
  input logic             sda_oe,
  input logic             cmd_done,
  input logic             arb_lost,
  input logic             active,
  input logic [2:0]       cmd_q
);
  // R2
  div_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    $past(enable) |-> $stable(div_q));

  // R11
  release_chk: assert property (@(posedge clk) disable iff (rst)
    !enable |=> (!scl_oe && !sda_oe && !cmd_done));

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    cmd_done |=> !cmd_done);

  // R9
  arb_release_chk: assert property (@(posedge clk) disable iff (rst)
    arb_lost |-> (cmd_done && !scl_oe && !sda_oe));

  // R8
  sda_move_chk: assert property (@(posedge clk) disable iff (rst)
    (active && (cmd_q == 3'd3 || cmd_q == 3'd4) && (sda_oe != $past(sda_oe)))
      |-> scl_oe);
endmodule

bind i2c_bit_engine i2cb_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst(rst), .enable(enable), .div_q(div_q), .scl_oe(scl_oe),
  .sda_oe(sda_oe), .cmd_done(cmd_done), .arb_lost(arb_lost),
  .active(active_q), .cmd_q(cmd_q)
);

// File: tb/tb_i2c_bit_engine.sv
module tb_i2c_bit_engine;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        enable = 1'b1;
  logic        div_wr = 1'b0;
  logic [15:0] div_wdata = '0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd = '0;
  logic        cmd_wbit = 1'b0;
  logic        scl_i, sda_i;
  logic        scl_oe, sda_oe, cmd_done, rx_bit, bus_busy, arb_lost;
  logic        stretch = 1'b0, slave_pull = 1'b0, rival_pull = 1'b0;
  int          n_tests = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  assign scl_i = ~scl_oe & ~stretch;
  assign sda_i = ~sda_oe & ~slave_pull & ~rival_pull;

  i2c_bit_engine dut (
    .clk(clk), .rst(rst), .enable(enable), .div_wr(div_wr), .div_wdata(div_wdata),
    .cmd_valid(cmd_valid), .cmd(cmd), .cmd_wbit(cmd_wbit), .scl_i(scl_i),
    .sda_i(sda_i), .scl_oe(scl_oe), .sda_oe(sda_oe), .cmd_done(cmd_done),
    .rx_bit(rx_bit), .bus_busy(bus_busy), .arb_lost(arb_lost)
  );

  function automatic int exp_cycles(int d); return 5 * (d + 1); endfunction
  function automatic int exp_low(int d);    return 2 * (d + 1); endfunction
  function automatic int exp_arb(int d);    return 3 * (d + 1); endfunction
  function automatic int exp_stretch(int d, int t); return 3 * (d + 1) + t + 3; endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_div(input int d);
    @(negedge clk);
    enable = 1'b0; div_wr = 1'b1; div_wdata = 16'(d);
    @(negedge clk);
    div_wr = 1'b0; enable = 1'b1;
  endtask

  // Issue one command; k = cycles from accepting edge to cmd_done.
  task automatic run_cmd(input logic [2:0] c, input logic b, input int rel_at,
                         output int k, output int low_cnt, output int sda_bad,
                         output logic arb_seen);
    @(negedge clk);
    cmd_valid = 1'b1; cmd = c; cmd_wbit = b;
    @(posedge clk);
    k = 0; low_cnt = 0; sda_bad = 0; arb_seen = 1'b0;
    forever begin
      @(negedge clk);
      cmd_valid = 1'b0;
      if (cmd_done) begin
        arb_seen = arb_lost;
        break;
      end
      if (scl_oe) low_cnt++;
      if (sda_oe != ~b) sda_bad++;
      if (k == rel_at) stretch = 1'b0;
      k++;
      if (k > 100000) break;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      check(1'b0, "watchdog", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int k, lo, bad, d;
    logic arb;
    void'($urandom(32'd4242));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(!scl_oe && !sda_oe && !cmd_done && !arb_lost && !bus_busy && !rx_bit,
          "R1 reset outputs", {scl_oe, sda_oe, cmd_done, arb_lost, bus_busy, rx_bit}, 0);
    run_cmd(3'd0, 1'b0, -1, k, lo, bad, arb);
    check(k == exp_cycles(302), "R1 default divider", k, exp_cycles(302));

    // R2 write while enabled is ignored
    @(negedge clk); div_wr = 1'b1; div_wdata = 16'd7;
    @(negedge clk); div_wr = 1'b0;
    run_cmd(3'd0, 1'b0, -1, k, lo, bad, arb);
    check(k == exp_cycles(302), "R2 write while enabled", k, exp_cycles(302));
    set_div(4);
    run_cmd(3'd7, 1'b0, -1, k, lo, bad, arb);
    check(k == exp_cycles(4), "R2 R3 write while disabled, code 7 idle", k, exp_cycles(4));

    for (int round = 0; round < 6; round++) begin
      d = 2 + int'($urandom % 14);
      set_div(d);
      run_cmd(3'd1, 1'b0, -1, k, lo, bad, arb);
      check(k == exp_cycles(d), "R3 start duration", k, exp_cycles(d));
      @(negedge clk);
      check(scl_oe && sda_oe && bus_busy, "R4 start end state",
            {scl_oe, sda_oe, bus_busy}, 7);
      for (int j = 0; j < 4; j++) begin
        logic bv;
        bv = logic'($urandom % 2);
        if ($urandom % 2 == 0) begin
          run_cmd(3'd3, bv, -1, k, lo, bad, arb);
          check(k == exp_cycles(d), "R3 write duration", k, exp_cycles(d));
          check(lo == exp_low(d), "R6 scl low time", lo, exp_low(d));
          check(bad == 0 && !arb, "R6 R9 sda level during write", bad, 0);
        end else begin
          slave_pull = ~bv;
          run_cmd(3'd4, 1'b1, -1, k, lo, bad, arb);
          slave_pull = 1'b0;
          check(k == exp_cycles(d), "R3 read duration", k, exp_cycles(d));
          check(bad == 0, "R7 sda released in read", bad, 0);
          check(rx_bit == bv, "R7 read bit", rx_bit, bv);
        end
      end
      run_cmd(3'd2, 1'b0, -1, k, lo, bad, arb);
      check(k == exp_cycles(d), "R3 stop duration", k, exp_cycles(d));
      @(negedge clk);
      check(!scl_oe && !sda_oe && !bus_busy, "R5 stop end state",
            {scl_oe, sda_oe, bus_busy}, 0);
    end

    // R9 arbitration
    set_div(3);
    run_cmd(3'd1, 1'b0, -1, k, lo, bad, arb);
    rival_pull = 1'b1;
    run_cmd(3'd3, 1'b0, -1, k, lo, bad, arb);
    check(!arb && k == exp_cycles(3), "R9 write 0 with rival", k, exp_cycles(3));
    run_cmd(3'd3, 1'b1, -1, k, lo, bad, arb);
    check(arb && k == exp_arb(3), "R9 arbitration lost timing", k, exp_arb(3));
    @(negedge clk);
    check(!scl_oe && !sda_oe, "R9 lines released", {scl_oe, sda_oe}, 0);
    rival_pull = 1'b0;
    run_cmd(3'd2, 1'b0, -1, k, lo, bad, arb);
    @(negedge clk);
    check(!bus_busy, "R5 stop after loss", bus_busy, 0);

    // R10 clock stretching
    set_div(4);
    run_cmd(3'd1, 1'b0, -1, k, lo, bad, arb);
    stretch = 1'b1;
    run_cmd(3'd3, 1'b0, 20, k, lo, bad, arb);
    check(k == exp_stretch(4, 20), "R10 stretched write", k, exp_stretch(4, 20));

    // R11 disable mid command
    @(negedge clk); cmd_valid = 1'b1; cmd = 3'd3; cmd_wbit = 1'b0;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (3) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    check(!scl_oe && !sda_oe, "R11 lines released", {scl_oe, sda_oe}, 0);
    begin
      int seen = 0;
      repeat (30) begin
        @(negedge clk);
        if (cmd_done) seen++;
      end
      check(seen == 0, "R11 no done after disable", seen, 0);
    end
    @(negedge clk); enable = 1'b1;
    run_cmd(3'd2, 1'b0, -1, k, lo, bad, arb);
    @(negedge clk);
    check(!bus_busy && k == exp_cycles(4), "R5 R11 stop after re-enable", k, exp_cycles(4));

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule